// File: doc/BRIEF.md
# Accelerator Address Remapping Unit

This block sits between a group of accelerator cores and main memory. It turns the virtual address of each core request into a physical address. The address channel carries a transaction ID, and that ID names the requesting core. A small fully associative first-level table is searched in the same cycle as the request. A first-level miss starts a search of a larger set-associative second-level table. That search examines one way per cycle, and the second-level table can be arbitrarily large.

If a request misses in both tables, the block writes a record of the miss into an internal queue and puts the requesting core to sleep. Software running on some core reads that queue through the configuration side, walks the page table itself, and writes a new table entry. It then wakes the core, which sends its access again. The second-level search does not block the first level: a core that hits in the first level is served while another core's second-level search runs. The block also reports how many ways the last search visited, so that entry placement can be judged.

Top module: `addr_remap_unit`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. It hits in the first level when some valid entry has lower bound <= VA <= upper bound and allows the access type (read needs the read-allowed bit, write needs the write-allowed bit). On a hit, `mem_valid` is high in the cycle after the accepting edge. In that cycle `mem_addr` = physical base + (VA - lower bound), and `mem_id` and `mem_write` copy the request.
- R2: A first-level miss starts a second-level search. The set index is VA bits [13:12] (the bits just above the 12-bit page offset), and the tag is VA[31:12]. Slot number = set*WAYS + way. Ways are visited from way 0 upward, one per cycle. A hit at way k drives `mem_valid` k+1 cycles after the accepting edge, with `mem_addr` = {stored page number, VA[11:0]}.
- R3: When a search ends, `walk_cycles` becomes the number of ways visited: k+1 on a hit at way k, and WAYS when no way hits.
- R4: While a second-level search is running, a request from another core that hits in the first level is accepted at once. Its result appears one cycle later, ahead of the search result.
- R5: While a search is running, a request that misses in the first level is held with `req_ready` low, and it is accepted in the cycle after the search ends.
- R6: A request that misses in both levels is queued as {core ID, write flag, VA} in first-in first-out order, and its core's `core_sleep` bit is set. The oldest record is shown on `mq_valid`/`mq_id`/`mq_write`/`mq_addr`, and `mq_pop` removes it.
- R7: When the miss queue already holds MQ_DEPTH records, a further double miss is not queued. The core is not put to sleep, and a one-cycle `err_valid` pulse carries its ID.
- R8: Requests from a core whose `core_sleep` bit is set are not accepted. `wake_valid` clears the bit for `wake_id`, and the re-sent access hits once software has written a matching entry.
- R9: An entry whose permission bit does not allow the access type is treated as absent, so the access goes on to the second level.
- R10: After reset, every table entry is invalid, the miss queue is empty, no core sleeps, and `mem_valid` and `err_valid` are low.
- R11: If several first-level entries match, the entry with the lowest index supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_id | input | ID_W | Requesting core (transaction ID) |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| mem_valid | output | 1 | Translated request toward memory |
| mem_id | output | ID_W | Core ID of translated request |
| mem_addr | output | 32 | Physical address |
| mem_write | output | 1 | Access type of translated request |
| err_valid | output | 1 | Error response (miss queue full) |
| err_id | output | ID_W | Core receiving the error |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_l2 | input | 1 | 0 = first-level table, 1 = second-level table |
| cfg_idx | input | CFG_IDX_W | Entry index (second level: set*WAYS+way) |
| cfg_vbase | input | 32 | Lower virtual bound (second level: page in bits 31:12) |
| cfg_vend | input | 32 | Upper virtual bound (first level only) |
| cfg_pbase | input | 32 | Physical base (second level: page in bits 31:12) |
| cfg_rd_ok | input | 1 | Reads allowed |
| cfg_wr_ok | input | 1 | Writes allowed |
| cfg_en | input | 1 | Entry valid |
| mq_valid | output | 1 | Miss queue not empty |
| mq_id | output | ID_W | Core of oldest miss |
| mq_addr | output | 32 | Virtual address of oldest miss |
| mq_write | output | 1 | Access type of oldest miss |
| mq_pop | input | 1 | Remove oldest miss |
| wake_valid | input | 1 | Wake strobe |
| wake_id | input | ID_W | Core to wake |
| core_sleep | output | NUM_CORES | Per-core sleep flags |
| walk_cycles | output | WAY_W+1 | Ways visited by the last second-level search |

## Verification
The properties assume well-behaved inputs. A core never sends a new request while its own earlier second-level search is still running. `req_id` always names an existing core. Software does not rewrite the set being searched in the middle of a search. The stimulus follows these rules: each core has at most one access in flight, any new requester is a different core from the one being searched, and all table writes are made while the block is idle. Expected translations are pushed into the scoreboard in the order the outputs are due to appear. Where the first level overtakes a search, that order differs from issue order.

// File: rtl/arm_pkg.sv
package arm_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PAGE_W = 12;
  localparam int unsigned VPN_W  = ADDR_W - PAGE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [VPN_W-1:0]  vpn_t;

  typedef enum logic {
    WK_IDLE   = 1'b0,
    WK_SEARCH = 1'b1
  } walk_st_e;

  typedef struct packed {
    logic ok_rd;
    logic ok_wr;
  } perm_t;

  typedef struct packed {
    logic  wr;
    addr_t va;
  } miss_rec_t;
endpackage

// File: rtl/arm_l1_tlb.sv
module arm_l1_tlb
  import arm_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  addr_t            cfg_vbase,
  input  addr_t            cfg_vend,
  input  addr_t            cfg_pbase,
  input  perm_t            cfg_perm,
  input  logic             cfg_en,
  input  addr_t            lk_va,
  input  logic             lk_wr,
  output logic             lk_hit,
  output addr_t            lk_pa
);

  addr_t vbase_q [ENTRIES];
  addr_t vend_q  [ENTRIES];
  addr_t pbase_q [ENTRIES];
  perm_t perm_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] match;
  logic [SEL_W-1:0]   pick;

  always_comb begin
    valid_d = valid_q;
    if (cfg_we) valid_d[cfg_sel] = cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      vbase_q[cfg_sel] <= cfg_vbase;
      vend_q[cfg_sel]  <= cfg_vend;
      pbase_q[cfg_sel] <= cfg_pbase;
      perm_q[cfg_sel]  <= cfg_perm;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign match[e] = valid_q[e] && (lk_va >= vbase_q[e]) && (lk_va <= vend_q[e]) &&
                      (lk_wr ? perm_q[e].ok_wr : perm_q[e].ok_rd);
  end

  always_comb begin
    pick = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) pick = SEL_W'(e);
    end
  end

  assign lk_hit = |match;
  assign lk_pa  = pbase_q[pick] + (lk_va - vbase_q[pick]);

endmodule

// File: rtl/arm_l2_walker.sv
module arm_l2_walker
  import arm_pkg::*;
#(
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 16,
  parameter int unsigned ID_W   = 2,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SLOT_W = SET_W + WAY_W,
  localparam int unsigned SLOTS  = SETS * WAYS,
  localparam int unsigned CYC_W  = WAY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  vpn_t              cfg_vpn,
  input  vpn_t              cfg_ppn,
  input  perm_t             cfg_perm,
  input  logic              cfg_en,
  input  logic              st_go,
  input  logic [ID_W-1:0]   st_id,
  input  addr_t             st_va,
  input  logic              st_wr,
  output logic              busy,
  output logic              fin_hit,
  output logic              fin_miss,
  output logic [ID_W-1:0]   res_id,
  output addr_t             res_va,
  output logic              res_wr,
  output addr_t             res_pa,
  output logic [CYC_W-1:0]  cycles_o
);

  vpn_t  tag_q  [SLOTS];
  vpn_t  ppn_q  [SLOTS];
  perm_t perm_q [SLOTS];
  logic [SLOTS-1:0] valid_q, valid_d;

  walk_st_e         st_q, st_d;
  logic [WAY_W-1:0] way_q, way_d;
  logic [SET_W-1:0] set_q, set_d;
  logic [ID_W-1:0]  id_q, id_d;
  addr_t            va_q, va_d;
  logic             wr_q, wr_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  logic [SLOT_W-1:0] slot;
  logic              probe_hit;
  logic              last_way;

  always_comb begin
    valid_d = valid_q;
    if (cfg_we) valid_d[cfg_slot] = cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      tag_q[cfg_slot]  <= cfg_vpn;
      ppn_q[cfg_slot]  <= cfg_ppn;
      perm_q[cfg_slot] <= cfg_perm;
    end
  end

  assign slot      = {set_q, way_q};
  assign busy      = (st_q == WK_SEARCH);
  assign last_way  = (way_q == WAY_W'(WAYS - 1));
  assign probe_hit = valid_q[slot] && (tag_q[slot] == va_q[ADDR_W-1:PAGE_W]) &&
                     (wr_q ? perm_q[slot].ok_wr : perm_q[slot].ok_rd);
  assign fin_hit   = busy && probe_hit;
  assign fin_miss  = busy && !probe_hit && last_way;
  assign res_id    = id_q;
  assign res_va    = va_q;
  assign res_wr    = wr_q;
  assign res_pa    = {ppn_q[slot], va_q[PAGE_W-1:0]};
  assign cycles_o  = cyc_q;

  always_comb begin
    st_d  = st_q;
    way_d = way_q;
    set_d = set_q;
    id_d  = id_q;
    va_d  = va_q;
    wr_d  = wr_q;
    cyc_d = cyc_q;
    if (st_q == WK_IDLE) begin
      if (st_go) begin
        st_d  = WK_SEARCH;
        way_d = '0;
        set_d = st_va[PAGE_W +: SET_W];
        id_d  = st_id;
        va_d  = st_va;
        wr_d  = st_wr;
      end
    end else begin
      if (fin_hit || fin_miss) begin
        st_d  = WK_IDLE;
        cyc_d = {1'b0, way_q} + CYC_W'(1);
      end else begin
        way_d = way_q + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      way_q <= '0;
      set_q <= '0;
      id_q  <= '0;
      va_q  <= '0;
      wr_q  <= 1'b0;
      cyc_q <= '0;
    end else begin
      st_q  <= st_d;
      way_q <= way_d;
      set_q <= set_d;
      id_q  <= id_d;
      va_q  <= va_d;
      wr_q  <= wr_d;
      cyc_q <= cyc_d;
    end
  end

endmodule

// File: rtl/arm_miss_fifo.sv
module arm_miss_fifo
  import arm_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned ID_W  = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  miss_rec_t       push_rec,
  input  logic            pop,
  output logic            full,
  output logic            empty,
  output logic [ID_W-1:0] head_id,
  output miss_rec_t       head_rec
);

  logic [ID_W-1:0] id_mem  [DEPTH];
  miss_rec_t       rec_mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign head_id  = id_mem[rp_q];
  assign head_rec = rec_mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
    if (do_pop)  rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      id_mem[wp_q]  <= push_id;
      rec_mem[wp_q] <= push_rec;
    end
  end

endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
  import arm_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned L1_ENTRIES = 8,
  parameter int unsigned L2_SETS    = 4,
  parameter int unsigned L2_WAYS    = 16,
  parameter int unsigned MQ_DEPTH   = 2,
  localparam int unsigned ID_W      = $clog2(NUM_CORES),
  localparam int unsigned L1_SEL_W  = $clog2(L1_ENTRIES),
  localparam int unsigned WAY_W     = $clog2(L2_WAYS),
  localparam int unsigned SLOT_W    = $clog2(L2_SETS) + WAY_W,
  localparam int unsigned CFG_IDX_W = (SLOT_W > L1_SEL_W) ? SLOT_W : L1_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic                 mem_valid,
  output logic [ID_W-1:0]      mem_id,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_write,
  output logic                 err_valid,
  output logic [ID_W-1:0]      err_id,
  input  logic                 cfg_we,
  input  logic                 cfg_l2,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_vbase,
  input  logic [ADDR_W-1:0]    cfg_vend,
  input  logic [ADDR_W-1:0]    cfg_pbase,
  input  logic                 cfg_rd_ok,
  input  logic                 cfg_wr_ok,
  input  logic                 cfg_en,
  output logic                 mq_valid,
  output logic [ID_W-1:0]      mq_id,
  output logic [ADDR_W-1:0]    mq_addr,
  output logic                 mq_write,
  input  logic                 mq_pop,
  input  logic                 wake_valid,
  input  logic [ID_W-1:0]      wake_id,
  output logic [NUM_CORES-1:0] core_sleep,
  output logic [WAY_W:0]       walk_cycles
);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  perm_t cfg_perm;
  assign cfg_perm = '{ok_rd: cfg_rd_ok, ok_wr: cfg_wr_ok};

  logic  l1_hit;
  addr_t l1_pa;

  arm_l1_tlb #(.ENTRIES(L1_ENTRIES)) l1_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .cfg_we    (cfg_we && !cfg_l2),
    .cfg_sel   (cfg_idx[L1_SEL_W-1:0]),
    .cfg_vbase (cfg_vbase),
    .cfg_vend  (cfg_vend),
    .cfg_pbase (cfg_pbase),
    .cfg_perm  (cfg_perm),
    .cfg_en    (cfg_en),
    .lk_va     (req_addr),
    .lk_wr     (req_write),
    .lk_hit    (l1_hit),
    .lk_pa     (l1_pa)
  );

  logic            accept, walk_go;
  logic            walk_busy, walk_fin_hit, walk_fin_miss;
  logic [ID_W-1:0] walk_id;
  addr_t           walk_va, walk_pa;
  logic            walk_wr;

  arm_l2_walker #(.SETS(L2_SETS), .WAYS(L2_WAYS), .ID_W(ID_W)) l2_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .cfg_we   (cfg_we && cfg_l2),
    .cfg_slot (cfg_idx[SLOT_W-1:0]),
    .cfg_vpn  (cfg_vbase[ADDR_W-1:PAGE_W]),
    .cfg_ppn  (cfg_pbase[ADDR_W-1:PAGE_W]),
    .cfg_perm (cfg_perm),
    .cfg_en   (cfg_en),
    .st_go    (walk_go),
    .st_id    (req_id),
    .st_va    (req_addr),
    .st_wr    (req_write),
    .busy     (walk_busy),
    .fin_hit  (walk_fin_hit),
    .fin_miss (walk_fin_miss),
    .res_id   (walk_id),
    .res_va   (walk_va),
    .res_wr   (walk_wr),
    .res_pa   (walk_pa),
    .cycles_o (walk_cycles)
  );

  logic      mq_full, mq_empty, mq_push;
  miss_rec_t mq_head;

  assign mq_push = walk_fin_miss && !mq_full;

  arm_miss_fifo #(.DEPTH(MQ_DEPTH), .ID_W(ID_W)) mq_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (mq_push),
    .push_id  (walk_id),
    .push_rec ('{wr: walk_wr, va: walk_va}),
    .pop      (mq_pop),
    .full     (mq_full),
    .empty    (mq_empty),
    .head_id  (mq_id),
    .head_rec (mq_head)
  );

  assign mq_valid = !mq_empty;
  assign mq_addr  = mq_head.va;
  assign mq_write = mq_head.wr;

  // request admission
  logic [NUM_CORES-1:0] sleep_q, sleep_d;

  assign req_ready = !sleep_q[req_id] && !(walk_busy && (!l1_hit || walk_fin_hit));
  assign accept    = req_valid && req_ready;
  assign walk_go   = accept && !l1_hit;

  always_comb begin
    sleep_d = sleep_q;
    if (wake_valid) sleep_d[wake_id] = 1'b0;
    if (mq_push)    sleep_d[walk_id] = 1'b1;
  end

  // output stage
  logic            mem_v_q, mem_v_d;
  logic [ID_W-1:0] mem_id_q, mem_id_d;
  addr_t           mem_pa_q, mem_pa_d;
  logic            mem_w_q, mem_w_d;
  logic            err_v_q, err_v_d;
  logic [ID_W-1:0] err_id_q, err_id_d;

  always_comb begin
    mem_v_d  = 1'b0;
    mem_id_d = mem_id_q;
    mem_pa_d = mem_pa_q;
    mem_w_d  = mem_w_q;
    if (accept && l1_hit) begin
      mem_v_d  = 1'b1;
      mem_id_d = req_id;
      mem_pa_d = l1_pa;
      mem_w_d  = req_write;
    end else if (walk_fin_hit) begin
      mem_v_d  = 1'b1;
      mem_id_d = walk_id;
      mem_pa_d = walk_pa;
      mem_w_d  = walk_wr;
    end
    err_v_d  = walk_fin_miss && mq_full;
    err_id_d = (walk_fin_miss && mq_full) ? walk_id : err_id_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sleep_q  <= '0;
      mem_v_q  <= 1'b0;
      mem_id_q <= '0;
      mem_pa_q <= '0;
      mem_w_q  <= 1'b0;
      err_v_q  <= 1'b0;
      err_id_q <= '0;
    end else begin
      sleep_q  <= sleep_d;
      mem_v_q  <= mem_v_d;
      mem_id_q <= mem_id_d;
      mem_pa_q <= mem_pa_d;
      mem_w_q  <= mem_w_d;
      err_v_q  <= err_v_d;
      err_id_q <= err_id_d;
    end
  end

  assign mem_valid  = mem_v_q;
  assign mem_id     = mem_id_q;
  assign mem_addr   = mem_pa_q;
  assign mem_write  = mem_w_q;
  assign err_valid  = err_v_q;
  assign err_id     = err_id_q;
  assign core_sleep = sleep_q;

endmodule

// File: rtl/arm_checker.sv
module arm_checker #(
  parameter int unsigned ID_W      = 2,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CYC_W     = 5,
  parameter int unsigned WAYS      = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [ID_W-1:0]      req_id,
  input logic                 l1_hit,
  input logic                 walk_busy,
  input logic                 walk_fin_hit,
  input logic                 walk_fin_miss,
  input logic [ID_W-1:0]      walk_id,
  input logic                 mq_full,
  input logic                 mem_valid,
  input logic [ID_W-1:0]      mem_id,
  input logic [NUM_CORES-1:0] core_sleep,
  input logic [CYC_W-1:0]     walk_cycles
);

  AST_L1_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && l1_hit) |=> (mem_valid && mem_id == $past(req_id))); // R1

  AST_WALK_CYCLES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_fin_hit || walk_fin_miss) |=> (walk_cycles >= CYC_W'(1) && walk_cycles <= CYC_W'(WAYS))); // R3

  AST_HIT_UNDER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && !walk_fin_hit && req_valid && l1_hit && !core_sleep[req_id]) |-> req_ready); // R4

  AST_MISS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && req_valid && !l1_hit) |-> !req_ready); // R5

  AST_SLEEP_ON_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_fin_miss && !mq_full) |=> core_sleep[$past(walk_id)]); // R6

  AST_FULL_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_fin_miss && mq_full && !core_sleep[walk_id]) |=> !core_sleep[$past(walk_id)]); // R7

  AST_ASLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && core_sleep[req_id]) |-> !req_ready); // R8

endmodule

bind addr_remap_unit arm_checker #(
  .ID_W(ID_W), .NUM_CORES(NUM_CORES), .CYC_W(WAY_W + 1), .WAYS(L2_WAYS)
) chk_i (
  .clk          (clk),
  .rst_n        (srst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_id       (req_id),
  .l1_hit       (l1_hit),
  .walk_busy    (walk_busy),
  .walk_fin_hit (walk_fin_hit),
  .walk_fin_miss(walk_fin_miss),
  .walk_id      (walk_id),
  .mq_full      (mq_full),
  .mem_valid    (mem_valid),
  .mem_id       (mem_id),
  .core_sleep   (core_sleep),
  .walk_cycles  (walk_cycles)
);

// File: tb/addr_remap_unit_tb_top.sv
module addr_remap_unit_tb_top;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [1:0] req_id;
  logic [31:0] req_addr;
  logic mem_valid, mem_write, err_valid;
  logic [1:0] mem_id, err_id;
  logic [31:0] mem_addr;
  logic cfg_we, cfg_l2, cfg_rd_ok, cfg_wr_ok, cfg_en;
  logic [5:0] cfg_idx;
  logic [31:0] cfg_vbase, cfg_vend, cfg_pbase;
  logic mq_valid, mq_write, mq_pop, wake_valid;
  logic [1:0] mq_id, wake_id;
  logic [31:0] mq_addr;
  logic [3:0] core_sleep;
  logic [4:0] walk_cycles;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int acc_cyc = 0;

  typedef struct packed {
    logic [1:0]  id;
    logic [31:0] pa;
    logic        wr;
  } exp_t;
  exp_t sb_q[$];

  addr_remap_unit dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected output", mem_addr, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(mem_id == e.id && mem_addr == e.pa && mem_write == e.wr, "R1/R2 output",
            {mem_id, mem_write, mem_addr[28:0]}, {e.id, e.wr, e.pa[28:0]});
      end
    end
  end

  task automatic expect_out(input logic [1:0] id, input logic [31:0] pa, input logic wr);
    sb_q.push_back('{id: id, pa: pa, wr: wr});
  endtask

  task automatic cfg_put(input logic l2, input int idx, input logic [31:0] vb, input logic [31:0] ve,
                         input logic [31:0] pb, input logic rd, input logic wr);
    cfg_we = 1'b1; cfg_l2 = l2; cfg_idx = 6'(idx);
    cfg_vbase = vb; cfg_vend = ve; cfg_pbase = pb;
    cfg_rd_ok = rd; cfg_wr_ok = wr; cfg_en = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] id, input logic [31:0] va, input logic wr);
    req_valid = 1'b1; req_id = id; req_addr = va; req_write = wr;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_one();
    mq_pop = 1'b1;
    @(negedge clk);
    mq_pop = 1'b0;
  endtask

  task automatic wake(input logic [1:0] id);
    wake_valid = 1'b1; wake_id = id;
    @(negedge clk);
    wake_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    int n;
    logic seen;
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_addr = '0; req_write = 1'b0;
    cfg_we = 1'b0; cfg_l2 = 1'b0; cfg_idx = '0; cfg_vbase = '0; cfg_vend = '0; cfg_pbase = '0;
    cfg_rd_ok = 1'b0; cfg_wr_ok = 1'b0; cfg_en = 1'b0;
    mq_pop = 1'b0; wake_valid = 1'b0; wake_id = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R10 reset state
    chk(!mem_valid && !err_valid, "R10 outputs quiet", {30'h0, mem_valid, err_valid}, 32'h0);
    chk(!mq_valid, "R10 queue empty", {31'h0, mq_valid}, 32'h0);
    chk(core_sleep == 4'h0, "R10 no sleep", {28'h0, core_sleep}, 32'h0);
    #1;
    chk(req_ready, "R10 ready", {31'h0, req_ready}, 32'h1);
    @(negedge clk);

    // first-level programming
    cfg_put(1'b0, 0, 32'h1000_0000, 32'h1000_FFFF, 32'h8000_0000, 1'b1, 1'b1);
    cfg_put(1'b0, 1, 32'h2000_0000, 32'h2000_0FFF, 32'h9000_0000, 1'b1, 1'b0);
    cfg_put(1'b0, 2, 32'h1000_0000, 32'h1000_00FF, 32'hA000_0000, 1'b1, 1'b1);
    // second-level: set 1 way 5, set 2 way 9
    cfg_put(1'b1, 1*16+5, 32'h3000_5000, 32'h0, 32'h7123_4000, 1'b1, 1'b1);
    cfg_put(1'b1, 2*16+9, 32'h3000_6000, 32'h0, 32'h5555_5000, 1'b1, 1'b1);

    // R1 / R11: back-to-back first-level hits
    expect_out(2'd0, 32'h8000_0010, 1'b0); // R11 lowest index wins over entry 2
    expect_out(2'd1, 32'h8000_1234, 1'b1);
    expect_out(2'd2, 32'h9000_0ABC, 1'b0);
    issue(2'd0, 32'h1000_0010, 1'b0);
    chk(mem_valid, "R1 one-cycle latency", {31'h0, mem_valid}, 32'h1);
    issue(2'd1, 32'h1000_1234, 1'b1);
    issue(2'd2, 32'h2000_0ABC, 1'b0);
    idle(2);
    chk(sb_q.size() == 0, "R1 all hits delivered", sb_q.size(), 32'h0);

    // R2 / R3: second-level hit at way 5
    expect_out(2'd3, 32'h7123_4678, 1'b0);
    issue(2'd3, 32'h3000_5678, 1'b0);
    n = 0;
    while (!mem_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == 6, "R2 hit at way 5 after 6 cycles", n, 32'd6);
    chk(walk_cycles == 5'd6, "R3 cycles on hit", {27'h0, walk_cycles}, 32'd6);
    idle(2);

    // R4 / R5: hit under miss, then a stalled first-level miss
    expect_out(2'd0, 32'h8000_0020, 1'b0);
    expect_out(2'd3, 32'h5555_5004, 1'b0);
    issue(2'd3, 32'h3000_6004, 1'b0);
    t0 = acc_cyc;
    issue(2'd0, 32'h1000_0020, 1'b0);
    chk(acc_cyc - t0 == 1, "R4 hit under miss accepted at once", acc_cyc - t0, 32'd1);
    issue(2'd1, 32'h4000_0000, 1'b0);
    chk(acc_cyc - t0 == 11, "R5 miss held until search ends", acc_cyc - t0, 32'd11);
    idle(20);
    chk(sb_q.size() == 0, "R4 order of results", sb_q.size(), 32'h0);

    // R6 / R3: full miss enqueued, core sleeps
    chk(core_sleep == 4'b0010, "R6 core 1 asleep", {28'h0, core_sleep}, 32'h2);
    chk(mq_valid && mq_id == 2'd1 && !mq_write, "R6 queue head id", {29'h0, mq_valid, mq_id}, 32'h5);
    chk(mq_addr == 32'h4000_0000, "R6 queue head addr", mq_addr, 32'h4000_0000);
    chk(walk_cycles == 5'd16, "R3 cycles on miss", {27'h0, walk_cycles}, 32'd16);

    // R8: sleeping core refused
    req_valid = 1'b1; req_id = 2'd1; req_addr = 32'h1000_0000; req_write = 1'b0;
    #1;
    chk(!req_ready, "R8 sleeping core refused", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_valid, "R8 no output for refused request", {31'h0, mem_valid}, 32'h0);

    // software handling, wake and retry
    pop_one();
    chk(!mq_valid, "R6 pop empties queue", {31'h0, mq_valid}, 32'h0);
    cfg_put(1'b0, 3, 32'h4000_0000, 32'h4000_0FFF, 32'hB000_0000, 1'b1, 1'b1);
    wake(2'd1);
    chk(core_sleep == 4'h0, "R8 wake clears sleep", {28'h0, core_sleep}, 32'h0);
    expect_out(2'd1, 32'hB000_0000, 1'b0);
    issue(2'd1, 32'h4000_0000, 1'b0);
    idle(2);
    chk(sb_q.size() == 0, "R8 retry hits", sb_q.size(), 32'h0);

    // R9: write to a read-only entry is a miss
    issue(2'd2, 32'h2000_0100, 1'b1);
    idle(20);
    chk(core_sleep == 4'b0100, "R9 permission miss sleeps core", {28'h0, core_sleep}, 32'h4);
    chk(mq_valid && mq_id == 2'd2 && mq_write, "R9 queued as write", {29'h0, mq_valid, mq_id}, 32'h6);
    chk(mq_addr == 32'h2000_0100, "R9 queued addr", mq_addr, 32'h2000_0100);
    pop_one();
    wake(2'd2);

    // R7: queue full gives an error response
    issue(2'd0, 32'h6000_0000, 1'b0);
    idle(20);
    issue(2'd1, 32'h6000_1000, 1'b1);
    idle(20);
    chk(core_sleep == 4'b0011, "R6 two sleepers", {28'h0, core_sleep}, 32'h3);
    issue(2'd2, 32'h6000_2000, 1'b0);
    n = 0; seen = 1'b0;
    while (!seen && n < 40) begin
      if (err_valid) seen = 1'b1;
      else begin
        @(negedge clk);
        n++;
      end
    end
    chk(seen && err_id == 2'd2, "R7 error to core 2", {29'h0, seen, err_id}, 32'h6);
    @(negedge clk);
    chk(!err_valid, "R7 error is one pulse", {31'h0, err_valid}, 32'h0);
    chk(core_sleep == 4'b0011, "R7 core 2 not asleep", {28'h0, core_sleep}, 32'h3);
    chk(mq_id == 2'd0 && mq_addr == 32'h6000_0000, "R7 queue unchanged head", mq_addr, 32'h6000_0000);
    pop_one();
    chk(mq_id == 2'd1 && mq_write && mq_addr == 32'h6000_1000, "R6 FIFO order", mq_addr, 32'h6000_1000);
    pop_one();
    chk(!mq_valid, "R7 no extra record", {31'h0, mq_valid}, 32'h0);
    wake(2'd0);
    wake(2'd1);
    idle(4);
    chk(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule